// File: doc/BRIEF.md
# Fault Latch and Alert Controller

This block holds the fault bookkeeping of a power-switch supervisor. Each fault source has two bits. A live "present" bit shows whether the condition holds right now. A sticky "fault" bit records that the condition happened. The inputs are digital condition flags that have already been qualified. Two exceptions are handled inside the block:

- The power-bad condition is qualified here with a cycle-count filter.
- The FET-short condition is gated here by the switch drive state.

A mask register selects which latched faults may pull the active-low alert output. Each alert fires once for each distinct fault occurrence. The host releases it by servicing an alert-response read or by addressing the device directly.

The host reaches three 8-bit registers through a simple write-strobe / combinational-read port:

| Address | Register | Access |
|---|---|---|
| 0 | Alert mask | Read/write |
| 1 | Status (present bits) | Read-only |
| 2 | Fault (sticky bits) | Write-zero-to-clear |

Several external events clear subsets of the fault register. A bit whose condition is still present cannot be cleared.

Fault bit map, shared by the status and fault registers:

| Bit | Meaning |
|---|---|
| 0, 1, 2 | Generic conditions from `fault_cond[2:0]` |
| 3 | Power-bad |
| 4 | Enable input changed state (no present bit) |
| 5 | FET short |
| 6, 7 | Always zero |

Top module: `fault_alert_ctrl`

## Requirements
- R1: Status bit 3 and fault bit 3 set together only after `fb_low`, `gate_on` and `vgs_ok` are all high on more than `QUAL_CYCLES` consecutive clock edges. A shorter burst, or any cycle where one of them is low, restarts the count.
- R2: The first edge at which the power-bad qualification fails clears status bit 3, while fault bit 3 stays set.
- R3: Status bits 0 to 2 follow `fault_cond` one edge later. Status bit 5 follows (`isense_hi` and not `gate_on`) one edge later. Each of these bits sets the matching fault bit at the same edge.
- R4: The mask is at address 0 and is zero after reset. `alert_n` is low only while some unserviced fault bit has its mask bit set. Setting a mask bit later exposes an unserviced fault that is already latched.
- R5: A one-cycle pulse on `ara_strobe` or `addr_strobe` releases `alert_n` high at the next edge.
- R6: A released alert stays high while faults merely continue. It asserts again when a different fault bit goes from 0 to 1, or when a bit is cleared and later sets again.
- R7: A host write to address 2 clears each fault bit written as 0, unless its present bit is high. Bits written as 1 are unchanged.
- R8: A high-to-low transition of `en_in` clears fault bits 0 to 3, except those still present, and sets fault bit 4.
- R9: A pulse on `off_evt`, `uv_rst_evt` or `uvlo_evt` clears the whole fault register, except bits still present.
- R10: When a fault bit is set and cleared at the same edge, it ends up set.
- R11: After reset, status, fault and mask read 0 and `alert_n` is high.
- R12: The status register at address 1 is read-only, so host writes there have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_cond | input | 3 | Qualified generic fault conditions for bits 0 to 2 |
| fb_low | input | 1 | Feedback below power-good threshold |
| gate_on | input | 1 | Switch drive is on |
| vgs_ok | input | 1 | Gate-to-source drive is adequate |
| isense_hi | input | 1 | Sensed current at or above the short threshold |
| en_in | input | 1 | Card-present enable level |
| off_evt | input | 1 | Switch turned off by the on input or control bit falling |
| uv_rst_evt | input | 1 | Undervoltage reset event |
| uvlo_evt | input | 1 | Undervoltage lockout event |
| ara_strobe | input | 1 | Alert-response read serviced |
| addr_strobe | input | 1 | Device directly addressed |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the current address |
| alert_n | output | 1 | Active-low alert (drive low, else release) |

## Verification
Power-bad qualification is tried with four patterns:
- a burst one cycle shorter than the filter window;
- a burst exactly long enough;
- a long burst with weak gate drive;
- a long burst with the gate off.

Together they separate an off-by-one in the filter from missing enable terms.

Alert re-arm is tried three ways:
- a condition that continues after service, which must stay quiet;
- a second, different fault, which must re-alert;
- an unmasked fault that becomes masked in later, which must alert.

Clear paths are tried three ways:
- each event with the condition released;
- each event with the condition still present;
- a clear colliding with a set in the same cycle.

Host writes of ones and writes to the status register are also tried. A behavioural model compares alert and read data every cycle.

// File: rtl/fa_pkg.sv
// Shared constants for the fault latch and alert controller.
// Assumes an 8-bit register file with fixed fault bit positions.
package fa_pkg;
    localparam int FW       = 8;
    localparam int NGEN     = 3;
    localparam int B_PBAD   = 3;
    localparam int B_ENCHG  = 4;
    localparam int B_FSHORT = 5;

    typedef enum logic [1:0] {
        A_MASK   = 2'd0,
        A_STATUS = 2'd1,
        A_FAULT  = 2'd2
    } reg_addr_e;
endpackage

// File: rtl/fa_pb_qual.sv
// Power-bad qualifier: reports a hit once feedback-low, gate-on and
// adequate gate drive have held on more than QUAL_CYCLES consecutive edges.
// Assumes QUAL_CYCLES >= 1. The output is combinational, so the
// consumer registers it.
module fa_pb_qual #(
    parameter int QUAL_CYCLES = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fb_low,
    input  logic gate_on,
    input  logic vgs_ok,
    output logic pb_hit
);
    localparam int CW = $clog2(QUAL_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(QUAL_CYCLES);

    logic          armed;
    logic [CW-1:0] run_cnt;

    assign armed  = fb_low && gate_on && vgs_ok;
    assign pb_hit = armed && (run_cnt == LIMIT);

    // Count consecutive qualifying cycles; saturate at the limit, restart on a gap.
    always_ff @(posedge clk) begin
        if (!rst_n)              run_cnt <= '0;
        else if (!armed)         run_cnt <= '0;
        else if (run_cnt != LIMIT) run_cnt <= run_cnt + 1'b1;
    end
endmodule

// File: rtl/fa_fault_latch.sv
// Status and sticky fault registers with the set and clear rules.
// Assumes present_d is this cycle's next status value and clr_all is a
// one-cycle event. Set always wins over clear.
module fa_fault_latch
    import fa_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] present_d,
    input  logic          en_in,
    input  logic          clr_all,
    input  logic          host_wr,
    input  logic [FW-1:0] host_wdata,
    output logic [FW-1:0] status_q,
    output logic [FW-1:0] fault_q,
    output logic [FW-1:0] fault_d,
    output logic [FW-1:0] fault_rise
);
    logic          en_q;
    logic          en_fall;
    logic [FW-1:0] set_vec;

    assign en_fall = en_q && !en_in;

    // Set vector: present conditions plus the enable-change marker.
    always_comb begin
        set_vec = present_d;
        set_vec[B_ENCHG] = present_d[B_ENCHG] | en_fall;
    end

    // Next fault value: host clears, then event clears, then sets on top.
    always_comb begin
        fault_d = fault_q;
        if (host_wr) fault_d = fault_d & (host_wdata | status_q);
        if (en_fall) fault_d[B_PBAD:0] = '0;
        if (clr_all) fault_d = '0;
        fault_d = fault_d | set_vec;
    end

    assign fault_rise = fault_d & ~fault_q;

    // Register status, fault and the previous enable level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            fault_q  <= '0;
            en_q     <= 1'b0;
        end else begin
            status_q <= present_d;
            fault_q  <= fault_d;
            en_q     <= en_in;
        end
    end

    for (genvar i = 0; i < FW; i++) begin : g_hold
        // R7: a present condition can never be cleared
        a_r7_present_holds: assert property (@(posedge clk) disable iff (!rst_n)
            present_d[i] |=> fault_q[i]);
    end

    a_r8_en_fall_sets4: assert property (@(posedge clk) disable iff (!rst_n)
        en_fall |=> fault_q[B_ENCHG]);

    a_r8_en_fall_clears_low: assert property (@(posedge clk) disable iff (!rst_n)
        (en_fall && present_d[B_PBAD:0] == '0) |=> (fault_q[B_PBAD:0] == '0));

    a_r9_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && present_d == '0 && !en_fall) |=> (fault_q == '0));
endmodule

// File: rtl/fa_alert_arm.sv
// One-shot alert arming: a bit becomes pending when its fault rises and
// stops pending when serviced or when its fault clears.
// Assumes fault_rise and fault_d come from the latch for the same edge.
module fa_alert_arm
    import fa_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] fault_d,
    input  logic [FW-1:0] fault_rise,
    input  logic [FW-1:0] mask_q,
    input  logic          ara_strobe,
    input  logic          addr_strobe,
    output logic          alert_n
);
    logic [FW-1:0] pend_q;
    logic          service;

    assign service = ara_strobe || addr_strobe;
    assign alert_n = ~|(pend_q & mask_q);

    // Track unserviced fault occurrences; a new rise wins over service.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= ((service ? '0 : pend_q) & fault_d) | fault_rise;
    end

    a_r5_service_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (service && fault_rise == '0) |=> alert_n);

    a_r6_no_rearm_same: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_n && fault_rise == '0) |=> (alert_n || !$stable(mask_q)));
endmodule

// File: rtl/fault_alert_ctrl.sv
// Top of the fault latch and alert controller: status and fault registers,
// alert mask, register access and alert output.
// Assumes all condition and event inputs are synchronous, already-qualified
// flags, except power-bad, which is filtered here.
module fault_alert_ctrl
    import fa_pkg::*;
#(
    parameter int QUAL_CYCLES = 250
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NGEN-1:0] fault_cond,
    input  logic            fb_low,
    input  logic            gate_on,
    input  logic            vgs_ok,
    input  logic            isense_hi,
    input  logic            en_in,
    input  logic            off_evt,
    input  logic            uv_rst_evt,
    input  logic            uvlo_evt,
    input  logic            ara_strobe,
    input  logic            addr_strobe,
    input  logic            reg_wr,
    input  logic [1:0]      reg_addr,
    input  logic [FW-1:0]   reg_wdata,
    output logic [FW-1:0]   reg_rdata,
    output logic            alert_n
);
    logic          pb_hit;
    logic [FW-1:0] present_d;
    logic [FW-1:0] status_q;
    logic [FW-1:0] fault_q;
    logic [FW-1:0] fault_d;
    logic [FW-1:0] fault_rise;
    logic [FW-1:0] mask_q;
    logic          wr_fault;

    fa_pb_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
        .clk(clk), .rst_n(rst_n), .fb_low(fb_low), .gate_on(gate_on),
        .vgs_ok(vgs_ok), .pb_hit(pb_hit)
    );

    // Assemble the next status value from the condition inputs.
    always_comb begin
        present_d = '0;
        present_d[NGEN-1:0] = fault_cond;
        present_d[B_PBAD]   = pb_hit;
        present_d[B_FSHORT] = isense_hi && !gate_on;
    end

    assign wr_fault = reg_wr && (reg_addr == A_FAULT);

    fa_fault_latch u_latch (
        .clk(clk), .rst_n(rst_n), .present_d(present_d), .en_in(en_in),
        .clr_all(off_evt || uv_rst_evt || uvlo_evt),
        .host_wr(wr_fault), .host_wdata(reg_wdata),
        .status_q(status_q), .fault_q(fault_q), .fault_d(fault_d),
        .fault_rise(fault_rise)
    );

    fa_alert_arm u_arm (
        .clk(clk), .rst_n(rst_n), .fault_d(fault_d), .fault_rise(fault_rise),
        .mask_q(mask_q), .ara_strobe(ara_strobe), .addr_strobe(addr_strobe),
        .alert_n(alert_n)
    );

    // Alert mask register, host writable, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                             mask_q <= '0;
        else if (reg_wr && reg_addr == A_MASK)  mask_q <= reg_wdata;
    end

    // Read data for the addressed register.
    always_comb begin
        case (reg_addr)
            A_MASK:   reg_rdata = mask_q;
            A_STATUS: reg_rdata = status_q;
            A_FAULT:  reg_rdata = fault_q;
            default:  reg_rdata = '0;
        endcase
    end

    a_r4_alert_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        !alert_n |-> |(fault_q & mask_q));

    a_r2_pb_status_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !(fb_low && gate_on && vgs_ok) |=> !status_q[B_PBAD]);
endmodule

// File: tb/fault_alert_ctrl_test.sv
`timescale 1ns/10ps
module fault_alert_ctrl_test;
    localparam int QC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] fault_cond = '0;
    logic       fb_low = 0, gate_on = 0, vgs_ok = 1, isense_hi = 0, en_in = 1;
    logic       off_evt = 0, uv_rst_evt = 0, uvlo_evt = 0;
    logic       ara_strobe = 0, addr_strobe = 0, reg_wr = 0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       alert_n;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    fault_alert_ctrl #(.QUAL_CYCLES(QC)) uut (
        .clk(clk), .rst_n(rst_n), .fault_cond(fault_cond), .fb_low(fb_low),
        .gate_on(gate_on), .vgs_ok(vgs_ok), .isense_hi(isense_hi), .en_in(en_in),
        .off_evt(off_evt), .uv_rst_evt(uv_rst_evt), .uvlo_evt(uvlo_evt),
        .ara_strobe(ara_strobe), .addr_strobe(addr_strobe), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .alert_n(alert_n)
    );

    always #4 clk = ~clk;

    // Behavioural reference model
    logic [7:0] m_mask, m_stat, m_fault, m_pend;
    int         m_run;
    logic       m_en_prev;

    always @(posedge clk) begin
        logic [7:0] st, f, set;
        logic       efall;
        if (!rst_n) begin
            m_mask = 0; m_stat = 0; m_fault = 0; m_pend = 0; m_run = 0; m_en_prev = 0;
        end else begin
            m_run = (fb_low && gate_on && vgs_ok) ? m_run + 1 : 0;
            st = 8'h00;
            st[2:0] = fault_cond;
            st[3] = (m_run > QC);
            st[5] = isense_hi && !gate_on;
            efall = m_en_prev && !en_in;
            f = m_fault;
            if (reg_wr && reg_addr == 2) f = f & (reg_wdata | m_stat);
            if (efall) f = f & 8'hF0;
            if (off_evt || uv_rst_evt || uvlo_evt) f = 8'h00;
            set = st;
            if (efall) set[4] = 1'b1;
            f = f | set;
            m_pend = (((ara_strobe || addr_strobe) ? 8'h00 : m_pend) & f) | (f & ~m_fault);
            if (reg_wr && reg_addr == 0) m_mask = reg_wdata;
            m_fault = f;
            m_stat = st;
            m_en_prev = en_in;
        end
    end

    function automatic logic [7:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return m_mask;
            2'd1: return m_stat;
            2'd2: return m_fault;
            default: return 8'h00;
        endcase
    endfunction

    // Per-cycle comparison against the model, just before each rising edge
    always begin
        @(negedge clk);
        #3.5;
        if (rst_n && !done) begin
            checks += 2;
            if (alert_n !== ~|(m_pend & m_mask)) begin
                bad++;
                $display("FAIL R4 model alert_n actual=%b expected=%b", alert_n, ~|(m_pend & m_mask));
            end
            if (reg_rdata !== m_read(reg_addr)) begin
                bad++;
                $display("FAIL R7 model rdata@%0d actual=%h expected=%h", reg_addr, reg_rdata, m_read(reg_addr));
            end
        end
    end

    task automatic step(input int n = 1);
        repeat (n) begin @(negedge clk); #0.5; end
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chkreg(input string tag, input logic [1:0] a, input logic [7:0] exp);
        reg_addr = a;
        #0.1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 0;
    endtask

    task automatic ara();
        ara_strobe = 1; step(); ara_strobe = 0;
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1;
        step();
        // R11 reset state
        chk("R11 alert_n", {7'd0, alert_n}, 8'h01);
        chkreg("R11 mask", 0, 8'h00);
        chkreg("R11 status", 1, 8'h00);
        chkreg("R11 fault", 2, 8'h00);

        // R4 mask write, then a generic fault
        wr(0, 8'hFF);
        chkreg("R4 mask", 0, 8'hFF);
        fault_cond = 3'b001; step(); fault_cond = 0;
        chk("R4 alert low", {7'd0, alert_n}, 8'h00);
        chkreg("R3 status gen", 1, 8'h01);
        chkreg("R3 fault gen", 2, 8'h01);
        step();
        chkreg("R3 status follows", 1, 8'h00);
        chkreg("R3 fault sticky", 2, 8'h01);
        wr(2, 8'h00);
        chkreg("R7 clear", 2, 8'h00);
        chk("R6 pend dropped", {7'd0, alert_n}, 8'h01);

        // R7 present protects, R5/R6 service and re-arm
        fault_cond = 3'b010; step();
        wr(2, 8'h00);
        chkreg("R7 present kept", 2, 8'h02);
        ara();
        chk("R5 ara release", {7'd0, alert_n}, 8'h01);
        step(3);
        chk("R6 continuing quiet", {7'd0, alert_n}, 8'h01);
        fault_cond = 3'b110; step();
        chk("R6 different fault", {7'd0, alert_n}, 8'h00);
        addr_strobe = 1; step(); addr_strobe = 0;
        chk("R5 addr release", {7'd0, alert_n}, 8'h01);
        fault_cond = 0; step();
        chkreg("R7 sticky after drop", 2, 8'h06);
        wr(2, 8'h00);
        chkreg("R7 cleared", 2, 8'h00);
        fault_cond = 3'b010; step(); fault_cond = 0;
        chk("R6 reoccur alerts", {7'd0, alert_n}, 8'h00);
        ara(); wr(2, 8'h00);

        // R4 masking and late unmask
        wr(0, 8'h00);
        fault_cond = 3'b001; step(); fault_cond = 0;
        chk("R4 masked quiet", {7'd0, alert_n}, 8'h01);
        wr(0, 8'hFF);
        chk("R4 late unmask", {7'd0, alert_n}, 8'h00);
        ara(); wr(2, 8'h00);

        // R1/R2 power-bad qualification
        gate_on = 1; vgs_ok = 1; fb_low = 1;
        step(QC);
        chkreg("R1 not yet", 1, 8'h00);
        step();
        chkreg("R1 status pb", 1, 8'h08);
        chkreg("R1 fault pb", 2, 8'h08);
        fb_low = 0; step();
        chkreg("R2 status clears", 1, 8'h00);
        chkreg("R2 fault stays", 2, 8'h08);
        ara(); wr(2, 8'h00);
        fb_low = 1; step(QC); fb_low = 0; step();
        chkreg("R1 short burst", 2, 8'h00);
        vgs_ok = 0; fb_low = 1; step(2 * QC);
        chkreg("R1 weak drive", 2, 8'h00);
        vgs_ok = 1; gate_on = 0; step(2 * QC);
        chkreg("R1 gate off", 2, 8'h00);
        fb_low = 0;

        // R3 FET short needs the gate off
        gate_on = 1; isense_hi = 1; step();
        chkreg("R3 short gate on", 1, 8'h00);
        gate_on = 0; step();
        chkreg("R3 short status", 1, 8'h20);
        chkreg("R3 short fault", 2, 8'h20);
        isense_hi = 0; step(); ara(); wr(2, 8'h00);

        // R8 enable falling edge
        fault_cond = 3'b111; step(); fault_cond = 3'b010;
        en_in = 0; step();
        chkreg("R8 en fall", 2, 8'h12);
        fault_cond = 0; en_in = 1; step();
        chkreg("R8 rise no effect", 2, 8'h12);
        ara(); wr(2, 8'h00);

        // R9 full clear events
        fault_cond = 3'b101; step(); fault_cond = 0;
        off_evt = 1; step(); off_evt = 0;
        chkreg("R9 off clear", 2, 8'h00);
        fault_cond = 3'b101; step(); fault_cond = 0;
        uv_rst_evt = 1; step(); uv_rst_evt = 0;
        chkreg("R9 uv clear", 2, 8'h00);
        fault_cond = 3'b101; step(); fault_cond = 3'b001;
        uvlo_evt = 1; step(); uvlo_evt = 0; fault_cond = 0;
        chkreg("R9 uvlo keeps present", 2, 8'h01);
        ara(); wr(2, 8'h00);

        // R10 set beats clear
        fault_cond = 3'b100; uv_rst_evt = 1; step(); uv_rst_evt = 0; fault_cond = 0;
        chkreg("R10 set vs event", 2, 8'h04);
        wr(2, 8'h00);
        fault_cond = 3'b001; wr(2, 8'h00); fault_cond = 0;
        chkreg("R10 set vs write", 2, 8'h01);
        ara(); wr(2, 8'h00);

        // R7 writes of ones, R12 status read-only
        wr(2, 8'hFF);
        chkreg("R7 ones no effect", 2, 8'h00);
        wr(1, 8'hFF);
        chkreg("R12 status ro", 1, 8'h00);
        chk("R4 idle alert", {7'd0, alert_n}, 8'h01);

        step(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule